// File: doc/BRIEF.md
# Virtual Interrupt Signal and Acknowledge Stage

This stage sits between the logic that picks the best pending virtual interrupt and the processor's virtual interrupt inputs. It takes one candidate interrupt: a valid flag, a 10-bit ID, a group bit and an 8-bit priority. It compares that priority against the virtual priority mask and gates it with the enable bit of its group. When the candidate passes both tests, it drives one of two level outputs, the virtual IRQ or the virtual FIQ.

A Group 0 interrupt goes to FIQ or to IRQ, as a routing control bit selects. A Group 1 interrupt always goes to IRQ. Both lines are registered.

The stage also answers two kinds of read. One is an acknowledge. The other is a highest-pending peek. Both kinds return the same ID one cycle after the request.

- An interrupt that cannot be signalled yields the spurious ID.
- A signallable Group 0 interrupt yields its own ID.
- A signallable Group 1 interrupt yields its own ID when the compatibility control bit is 1.
- A signallable Group 1 interrupt yields the reserved ID 1022 when that bit is 0.

Top module: `virq_signal`

## Requirements
- R1: While rst_n is low and in the first cycle after it, virq_o, vfiq_o and rd_valid_o are 0.
- R2: A candidate is signallable only if cand_valid_i is 1 and cand_prio_i is numerically strictly below prio_mask_i. A priority equal to the mask is not signallable.
- R3: A candidate with cand_grp_i = 0 (Group 0) is signallable only when grp0_en_i is 1.
- R4: A candidate with cand_grp_i = 1 (Group 1) is signallable only when grp1_en_i is 1.
- R5: A signallable Group 0 candidate raises vfiq_o when fiq_route_i is 1 and raises virq_o when fiq_route_i is 0.
- R6: A signallable Group 1 candidate raises virq_o regardless of fiq_route_i, and never raises vfiq_o.
- R7: virq_o and vfiq_o show the inputs sampled at the previous rising edge. At most one of them is 1, and both are 0 when nothing is signallable.
- R8: When ack_req_i or peek_req_i is 1 at a rising edge, rd_valid_o is 1 in the following cycle with rd_id_o set. Otherwise rd_valid_o is 0 in that cycle.
- R9: For a signallable Group 1 candidate with legacy_ack_i = 0, the returned ID is 1022.
- R10: For a signallable Group 1 candidate with legacy_ack_i = 1, the returned ID is cand_id_i. For a signallable Group 0 candidate, the returned ID is cand_id_i whatever legacy_ack_i is.
- R11: When the candidate is not signallable, the returned ID is 1023.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prio_mask_i | input | 8 | Virtual priority mask |
| grp0_en_i | input | 1 | Group 0 enable |
| grp1_en_i | input | 1 | Group 1 enable |
| fiq_route_i | input | 1 | Route Group 0 interrupts to FIQ when 1 |
| legacy_ack_i | input | 1 | Return real Group 1 IDs when 1, ID 1022 when 0 |
| cand_valid_i | input | 1 | Candidate interrupt present |
| cand_id_i | input | 10 | Candidate interrupt ID |
| cand_grp_i | input | 1 | Candidate group: 0 or 1 |
| cand_prio_i | input | 8 | Candidate priority, lower value is more urgent |
| ack_req_i | input | 1 | Acknowledge read request |
| peek_req_i | input | 1 | Highest-pending read request |
| virq_o | output | 1 | Virtual IRQ level |
| vfiq_o | output | 1 | Virtual FIQ level |
| rd_valid_o | output | 1 | Read response valid |
| rd_id_o | output | 10 | Read response ID |

## Verification
A read request and a change of the line outputs can land on the same rising edge. Both are then computed from the same candidate and control values. The random phase issues acknowledge and peek requests, alone or together, while the candidate, the mask, the enables and the routing bits change every cycle. In the cycle after each edge, the bench checks the two line levels and the returned ID together against one reference decision. A returned ID that does not match the line state it should accompany is therefore caught, including on the cycles where the candidate's priority sits exactly at the mask.

// File: rtl/vsig_pkg.sv
package vsig_pkg;
   typedef enum logic [1:0] {
      LINE_NONE = 2'd0,
      LINE_IRQ  = 2'd1,
      LINE_FIQ  = 2'd2
   } line_e;
endpackage

// File: rtl/vsig_eligible.sv
module vsig_eligible #(
   parameter int PRIO_W = 8
) (
   input  logic              valid_i,
   input  logic              grp_i,
   input  logic [PRIO_W-1:0] prio_i,
   input  logic [PRIO_W-1:0] mask_i,
   input  logic              g0_en_i,
   input  logic              g1_en_i,
   output logic              ok_o
);
   logic beats_mask;
   logic grp_on;

   always_comb begin
      beats_mask = (prio_i < mask_i);
      grp_on     = grp_i ? g1_en_i : g0_en_i;
      ok_o       = valid_i && beats_mask && grp_on;
   end
endmodule

// File: rtl/vsig_route.sv
module vsig_route
   import vsig_pkg::*;
(
   input  logic  ok_i,
   input  logic  grp_i,
   input  logic  fiq_route_i,
   output line_e line_o
);
   always_comb begin
      if (!ok_i)
         line_o = LINE_NONE;
      else if (!grp_i && fiq_route_i)
         line_o = LINE_FIQ;
      else
         line_o = LINE_IRQ;
   end
endmodule

// File: rtl/vsig_lines.sv
module vsig_lines
   import vsig_pkg::*;
#(
   parameter bit REG_OUT = 1'b1
) (
   input  logic  clk,
   input  logic  rst_n,
   input  line_e line_i,
   output logic  irq_o,
   output logic  fiq_o
);
   logic irq_d;
   logic fiq_d;

   always_comb begin
      irq_d = (line_i == LINE_IRQ);
      fiq_d = (line_i == LINE_FIQ);
   end

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            irq_o <= 1'b0;
            fiq_o <= 1'b0;
         end else begin
            irq_o <= irq_d;
            fiq_o <= fiq_d;
         end
      end
   end else begin : g_comb
      always_comb begin
         irq_o = irq_d;
         fiq_o = fiq_d;
      end
   end

   // R7
   lines_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({irq_o, fiq_o}) <= 1);
endmodule

// File: rtl/vsig_idsel.sv
module vsig_idsel #(
   parameter int ID_W = 10
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            req_i,
   input  logic            ok_i,
   input  logic            grp_i,
   input  logic            legacy_ack_i,
   input  logic [ID_W-1:0] id_i,
   output logic            valid_o,
   output logic [ID_W-1:0] id_o
);
   localparam logic [ID_W-1:0] ID_SPURIOUS = {ID_W{1'b1}};
   localparam logic [ID_W-1:0] ID_HIDDEN_G1 = {{(ID_W-1){1'b1}}, 1'b0};

   logic [ID_W-1:0] id_d;

   always_comb begin
      if (!ok_i)
         id_d = ID_SPURIOUS;
      else if (grp_i && !legacy_ack_i)
         id_d = ID_HIDDEN_G1;
      else
         id_d = id_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_o <= 1'b0;
         id_o    <= ID_SPURIOUS;
      end else begin
         valid_o <= req_i;
         if (req_i)
            id_o <= id_d;
      end
   end

   // R8
   rd_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> $past(req_i));
   // R11
   spurious_when_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && !$past(ok_i)) |-> (id_o == ID_SPURIOUS));
endmodule

// File: rtl/virq_signal.sv
module virq_signal
   import vsig_pkg::*;
#(
   parameter int ID_W    = 10,
   parameter int PRIO_W  = 8,
   parameter bit REG_OUT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [PRIO_W-1:0] prio_mask_i,
   input  logic              grp0_en_i,
   input  logic              grp1_en_i,
   input  logic              fiq_route_i,
   input  logic              legacy_ack_i,
   input  logic              cand_valid_i,
   input  logic [ID_W-1:0]   cand_id_i,
   input  logic              cand_grp_i,
   input  logic [PRIO_W-1:0] cand_prio_i,
   input  logic              ack_req_i,
   input  logic              peek_req_i,
   output logic              virq_o,
   output logic              vfiq_o,
   output logic              rd_valid_o,
   output logic [ID_W-1:0]   rd_id_o
);
   localparam logic [ID_W-1:0] ID_HIDDEN_G1 = {{(ID_W-1){1'b1}}, 1'b0};

   if (ID_W < 2) begin : g_bad_id_w
      $error("virq_signal: ID_W must be at least 2");
   end
   if (PRIO_W < 1) begin : g_bad_prio_w
      $error("virq_signal: PRIO_W must be at least 1");
   end

   logic  ok;
   line_e line_sel;
   logic  rd_req;

   always_comb rd_req = ack_req_i | peek_req_i;

   vsig_eligible #(.PRIO_W(PRIO_W)) u_elig (
      .valid_i (cand_valid_i),
      .grp_i   (cand_grp_i),
      .prio_i  (cand_prio_i),
      .mask_i  (prio_mask_i),
      .g0_en_i (grp0_en_i),
      .g1_en_i (grp1_en_i),
      .ok_o    (ok)
   );

   vsig_route u_route (
      .ok_i        (ok),
      .grp_i       (cand_grp_i),
      .fiq_route_i (fiq_route_i),
      .line_o      (line_sel)
   );

   vsig_lines #(.REG_OUT(REG_OUT)) u_lines (
      .clk    (clk),
      .rst_n  (rst_n),
      .line_i (line_sel),
      .irq_o  (virq_o),
      .fiq_o  (vfiq_o)
   );

   vsig_idsel #(.ID_W(ID_W)) u_idsel (
      .clk          (clk),
      .rst_n        (rst_n),
      .req_i        (rd_req),
      .ok_i         (ok),
      .grp_i        (cand_grp_i),
      .legacy_ack_i (legacy_ack_i),
      .id_i         (cand_id_i),
      .valid_o      (rd_valid_o),
      .id_o         (rd_id_o)
   );

   if (REG_OUT) begin : g_line_chk
      // R2
      mask_strict_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (virq_o || vfiq_o) |-> $past(cand_valid_i && (cand_prio_i < prio_mask_i)));
      // R5
      fiq_needs_grp0_chk: assert property (@(posedge clk) disable iff (!rst_n)
         vfiq_o |-> $past(!cand_grp_i && fiq_route_i && grp0_en_i));
      // R6
      grp1_never_fiq_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $past(cand_grp_i) |-> !vfiq_o);
   end

   // R9
   hidden_g1_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid_o && $past(ok && cand_grp_i && !legacy_ack_i)) |-> (rd_id_o == ID_HIDDEN_G1));
endmodule

// File: tb/virq_signal_tb.sv
`timescale 1ns/1ps
module virq_signal_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] prio_mask_i = '0;
   logic       grp0_en_i = 0, grp1_en_i = 0, fiq_route_i = 0, legacy_ack_i = 0;
   logic       cand_valid_i = 0, cand_grp_i = 0;
   logic [9:0] cand_id_i = '0;
   logic [7:0] cand_prio_i = '0;
   logic       ack_req_i = 0, peek_req_i = 0;
   logic       virq_o, vfiq_o, rd_valid_o;
   logic [9:0] rd_id_o;

   int checks = 0;
   int errors = 0;
   int seed_dummy;

   always #10 clk = ~clk;

   virq_signal u_dut (
      .clk(clk), .rst_n(rst_n), .prio_mask_i(prio_mask_i), .grp0_en_i(grp0_en_i),
      .grp1_en_i(grp1_en_i), .fiq_route_i(fiq_route_i), .legacy_ack_i(legacy_ack_i),
      .cand_valid_i(cand_valid_i), .cand_id_i(cand_id_i), .cand_grp_i(cand_grp_i),
      .cand_prio_i(cand_prio_i), .ack_req_i(ack_req_i), .peek_req_i(peek_req_i),
      .virq_o(virq_o), .vfiq_o(vfiq_o), .rd_valid_o(rd_valid_o), .rd_id_o(rd_id_o)
   );

   function automatic bit ref_ok();
      bit en;
      en = cand_grp_i ? grp1_en_i : grp0_en_i;
      return cand_valid_i && (cand_prio_i < prio_mask_i) && en;
   endfunction

   function automatic bit ref_fiq();
      return ref_ok() && !cand_grp_i && fiq_route_i;
   endfunction

   function automatic bit ref_irq();
      return ref_ok() && !(!cand_grp_i && fiq_route_i);
   endfunction

   function automatic logic [9:0] ref_id();
      if (!ref_ok()) return 10'd1023;
      if (cand_grp_i && !legacy_ack_i) return 10'd1022;
      return cand_id_i;
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Drive at negedge, step one edge, check outputs 1 ns after it.
   task automatic step_check(input string tag);
      bit         e_irq, e_fiq, e_rv;
      logic [9:0] e_id;
      e_irq = ref_irq();
      e_fiq = ref_fiq();
      e_rv  = ack_req_i | peek_req_i;
      e_id  = ref_id();
      @(posedge clk);
      #1;
      chk({tag, " R7 irq"}, virq_o, e_irq);
      chk({tag, " R7 fiq"}, vfiq_o, e_fiq);
      chk({tag, " R8 rd_valid"}, rd_valid_o, e_rv);
      if (e_rv) chk({tag, " R8 rd_id"}, rd_id_o, e_id);
      @(negedge clk);
   endtask

   task automatic set_cand(input bit v, input bit g, input logic [9:0] id, input logic [7:0] p);
      cand_valid_i = v; cand_grp_i = g; cand_id_i = id; cand_prio_i = p;
   endtask

   initial begin
      #2000000;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      seed_dummy = $urandom(32'h5eed_1234);
      // R1: reset state
      repeat (3) @(negedge clk);
      chk("R1 virq in reset", virq_o, 0);
      chk("R1 vfiq in reset", vfiq_o, 0);
      chk("R1 rd_valid in reset", rd_valid_o, 0);
      rst_n = 1'b1;
      @(posedge clk); #1;
      chk("R1 virq after reset", virq_o, 0);
      chk("R1 rd_valid after reset", rd_valid_o, 0);
      @(negedge clk);

      grp0_en_i = 1; grp1_en_i = 1; prio_mask_i = 8'h80; ack_req_i = 1;
      // R2: boundary at mask
      set_cand(1, 0, 10'd33, 8'h80);
      step_check("R2 equal");
      chk("R2 equal masked", virq_o | vfiq_o, 0);
      set_cand(1, 0, 10'd33, 8'h7f);
      step_check("R2 below");
      chk("R2 below signalled", virq_o, 1);
      prio_mask_i = 8'h00;
      set_cand(1, 0, 10'd33, 8'h00);
      step_check("R2 mask zero");
      chk("R11 mask zero spurious", rd_id_o, 1023);
      prio_mask_i = 8'hff;
      set_cand(0, 1, 10'd7, 8'h00);
      step_check("R2 invalid");
      // R3 / R4: group gating
      grp0_en_i = 0;
      set_cand(1, 0, 10'd55, 8'h10);
      step_check("R3 g0 off");
      chk("R3 g0 off id", rd_id_o, 1023);
      grp0_en_i = 1; grp1_en_i = 0;
      set_cand(1, 1, 10'd56, 8'h10);
      step_check("R4 g1 off");
      chk("R4 g1 off lines", virq_o | vfiq_o, 0);
      grp1_en_i = 1;
      // R5: routing
      fiq_route_i = 1;
      set_cand(1, 0, 10'd90, 8'h10);
      step_check("R5 fiq");
      chk("R5 fiq raised", vfiq_o, 1);
      fiq_route_i = 0;
      step_check("R5 irq");
      chk("R5 irq raised", virq_o, 1);
      // R6: group 1 ignores routing
      fiq_route_i = 1;
      set_cand(1, 1, 10'd91, 8'h10);
      step_check("R6 g1");
      chk("R6 g1 irq", virq_o, 1);
      chk("R6 g1 no fiq", vfiq_o, 0);
      // R9 / R10: ID return
      legacy_ack_i = 0;
      step_check("R9 hidden");
      chk("R9 id 1022", rd_id_o, 1022);
      legacy_ack_i = 1;
      step_check("R10 real");
      chk("R10 g1 real id", rd_id_o, 91);
      legacy_ack_i = 0;
      set_cand(1, 0, 10'd1021, 8'h10);
      step_check("R10 g0");
      chk("R10 g0 real id", rd_id_o, 1021);
      // R8: no request
      ack_req_i = 0; peek_req_i = 0;
      step_check("R8 idle");
      chk("R8 idle valid", rd_valid_o, 0);
      peek_req_i = 1;
      step_check("R8 peek");

      // Random mix: reads and line changes together
      for (int i = 0; i < 600; i++) begin
         prio_mask_i  = 8'($urandom);
         grp0_en_i    = 1'($urandom);
         grp1_en_i    = 1'($urandom);
         fiq_route_i  = 1'($urandom);
         legacy_ack_i = 1'($urandom);
         cand_valid_i = ($urandom % 8) != 0;
         cand_grp_i   = 1'($urandom);
         cand_id_i    = 10'($urandom);
         cand_prio_i  = ($urandom % 4 == 0) ? prio_mask_i - 8'(($urandom % 2)) : 8'($urandom);
         ack_req_i    = 1'($urandom);
         peek_req_i   = 1'($urandom);
         step_check("random R2 R3 R4 R5 R6 R9 R10 R11");
      end

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule